// File: doc/BRIEF.md
# High-Speed Burst Transmit Sequencer

This block sequences one data lane's transmitter through a single high-speed burst. While idle, the lane holds the low-power stop level. A request from the protocol side starts a timed low-power entry: a request level, then a bridge level. Next comes a zero preamble on the high-speed driver and a fixed sync byte. Payload bytes then arrive over a valid/ready handshake and are serialized one bit per clock, least-significant bit first. The burst closes with a trailer that holds the complement of the last bit sent. A timed stop interval follows before the lane goes back to idle.

Every interval length is a cycle count supplied as an input, and each must be at least 1. The outputs are the two-wire low-power line level `{Dp,Dn}`, separate enables for the high-speed and low-power drivers, the serial high-speed bit, and a busy flag. The burst ends when the byte source has no valid byte on a byte boundary, which is the cycle in which `byte_ready` is high. The block has eight states, and each transition is named in the requirements:

- STOP → REQ on request.
- REQ → BRIDGE after TLPX.
- BRIDGE → ZERO after the prepare interval.
- ZERO → SYNC after the zero interval.
- SYNC → DATA when a byte is accepted, or SYNC → TRAIL when none is offered.
- DATA → DATA when a byte is accepted, or DATA → TRAIL when none is offered.
- TRAIL → EXIT after the trail interval.
- EXIT → STOP after the exit interval.

Top module: `hsb_tx_seq`

## Requirements
- R1: After reset, and in STOP, the lane drives `lp_line`=2'b11 with `lp_en`=1, `hs_en`=0, `hs_bit`=0 and `busy`=0; only `hs_req` leaves STOP, and `byte_valid` has no effect there.
- R2: One cycle after `hs_req` is seen in STOP, the lane enters REQ and drives `lp_line`=2'b01 for `t_lpx` cycles. It then enters BRIDGE and drives `lp_line`=2'b00 for `t_prep` cycles, with `lp_en`=1 and `hs_en`=0 throughout.
- R3: In the cycle the bridge ends, `hs_en` rises and `lp_en` falls together (state ZERO). `hs_bit`=0 is then driven for `t_zero` cycles, with `lp_line` at 2'b00 whenever `hs_en`=1.
- R4: State SYNC sends exactly 8 bits in the order 0,0,0,1,1,1,0,1 and is directly followed by the first payload bit.
- R5: Payload bytes are sent least-significant bit first with no gap between bytes. `byte_ready` is high only in the last bit cycle of SYNC or of a byte, and a byte is taken when `byte_valid` is also high.
- R6: If `byte_valid` is low while `byte_ready` is high, the lane enters TRAIL and drives the complement of the last bit sent for `t_trail` cycles. With no payload, that last bit is the final sync bit (1), so the trailer is 0.
- R7: After the trailer, `hs_en` falls and `lp_en` rises in the same cycle (state EXIT). `lp_line`=2'b11 is then driven for `t_exit` cycles before STOP.
- R8: `busy` is high from the cycle after the accepted request until EXIT completes, and `hs_req` pulses while busy are ignored.
- R9: An interval input of 1 gives a state that lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_req | input | 1 | Protocol request to start a burst |
| t_lpx | input | CNT_W | Request-level duration in cycles (≥1) |
| t_prep | input | CNT_W | Bridge-level duration in cycles (≥1) |
| t_zero | input | CNT_W | Zero preamble duration in cycles (≥1) |
| t_trail | input | CNT_W | Trailer duration in cycles (≥1) |
| t_exit | input | CNT_W | Closing stop duration in cycles (≥1) |
| byte_data | input | 8 | Payload byte |
| byte_valid | input | 1 | Payload byte is available |
| byte_ready | output | 1 | Block takes the byte at this clock edge if valid |
| lp_line | output | 2 | Low-power line level {Dp,Dn} |
| hs_en | output | 1 | High-speed driver enable |
| lp_en | output | 1 | Low-power driver enable |
| hs_bit | output | 1 | Serial high-speed bit |
| busy | output | 1 | Burst in progress |

## Verification
The assertions check the following on every cycle:

- the same-cycle driver handoff at both ends of the high-speed period;
- that a request level is always followed by the bridge level;
- that `byte_ready` never appears outside high-speed driving;
- that an idle lane always sits at the stop level.

The exact interval lengths, the sync pattern, the bit order of the payload, the value of the trailer for each last-bit case, and the rejection of requests during a burst depend on the programmed counts and the data. Only the bench's per-cycle scoreboard against independently built burst traces can show these.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
    typedef enum logic [2:0] {
        ST_STOP,
        ST_REQ,
        ST_BRIDGE,
        ST_ZERO,
        ST_SYNC,
        ST_DATA,
        ST_TRAIL,
        ST_EXIT
    } hsb_state_e;

    localparam int          BYTE_W   = 8;
    // sync byte as a shift-register image: bit 0 is sent first (0,0,0,1,1,1,0,1)
    localparam logic [7:0]  SYNC_IMG = 8'hB8;

    localparam logic [1:0]  LP_STOP   = 2'b11;
    localparam logic [1:0]  LP_HSREQ  = 2'b01;
    localparam logic [1:0]  LP_BRIDGE = 2'b00;
endpackage

// File: rtl/hsb_timer.sv
module hsb_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/hsb_ser.sv
module hsb_ser #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift_en,
    output logic         out_bit,
    output logic         last
);
    localparam int IDX_W = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]     sr_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sr_q  <= load_val;
            idx_q <= '0;
        end else if (shift_en) begin
            sr_q  <= sr_q >> 1;
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    assign out_bit = sr_q[0];
    assign last    = (idx_q == IDX_W'(W - 1));
endmodule

// File: rtl/hsb_tx_seq.sv
module hsb_tx_seq
    import hsb_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_req,
    input  logic [CNT_W-1:0] t_lpx,
    input  logic [CNT_W-1:0] t_prep,
    input  logic [CNT_W-1:0] t_zero,
    input  logic [CNT_W-1:0] t_trail,
    input  logic [CNT_W-1:0] t_exit,
    input  logic [7:0]       byte_data,
    input  logic             byte_valid,
    output logic             byte_ready,
    output logic [1:0]       lp_line,
    output logic             hs_en,
    output logic             lp_en,
    output logic             hs_bit,
    output logic             busy
);
    hsb_state_e       state_q, state_d;
    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic             ser_load, ser_shift, ser_bit, ser_last;
    logic [BYTE_W-1:0] ser_val;
    logic             trail_cap, trail_q;

    hsb_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    hsb_ser #(.W(BYTE_W)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ser_load),
        .load_val (ser_val),
        .shift_en (ser_shift),
        .out_bit  (ser_bit),
        .last     (ser_last)
    );

    // next state and sub-block controls
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        ser_load  = 1'b0;
        ser_val   = byte_data;
        trail_cap = 1'b0;
        unique case (state_q)
            ST_STOP: if (hs_req) begin
                state_d  = ST_REQ;
                tmr_load = 1'b1;
                tmr_val  = t_lpx - CNT_W'(1);
            end
            ST_REQ: if (tmr_done) begin
                state_d  = ST_BRIDGE;
                tmr_load = 1'b1;
                tmr_val  = t_prep - CNT_W'(1);
            end
            ST_BRIDGE: if (tmr_done) begin
                state_d  = ST_ZERO;
                tmr_load = 1'b1;
                tmr_val  = t_zero - CNT_W'(1);
            end
            ST_ZERO: if (tmr_done) begin
                state_d  = ST_SYNC;
                ser_load = 1'b1;
                ser_val  = SYNC_IMG;
            end
            ST_SYNC, ST_DATA: if (ser_last) begin
                if (byte_valid) begin
                    state_d  = ST_DATA;
                    ser_load = 1'b1;
                end else begin
                    state_d   = ST_TRAIL;
                    trail_cap = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = t_trail - CNT_W'(1);
                end
            end
            ST_TRAIL: if (tmr_done) begin
                state_d  = ST_EXIT;
                tmr_load = 1'b1;
                tmr_val  = t_exit - CNT_W'(1);
            end
            ST_EXIT: if (tmr_done) state_d = ST_STOP;
            default: state_d = ST_STOP;
        endcase
    end

    assign ser_shift = (state_q == ST_SYNC) || (state_q == ST_DATA);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
            trail_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (trail_cap) trail_q <= ~ser_bit;
        end
    end

    // outputs
    always_comb begin
        lp_line    = LP_STOP;
        lp_en      = 1'b1;
        hs_en      = 1'b0;
        hs_bit     = 1'b0;
        byte_ready = 1'b0;
        busy       = 1'b1;
        unique case (state_q)
            ST_STOP:   busy = 1'b0;
            ST_REQ:    lp_line = LP_HSREQ;
            ST_BRIDGE: lp_line = LP_BRIDGE;
            ST_ZERO: begin
                lp_line = LP_BRIDGE;
                lp_en   = 1'b0;
                hs_en   = 1'b1;
            end
            ST_SYNC, ST_DATA: begin
                lp_line    = LP_BRIDGE;
                lp_en      = 1'b0;
                hs_en      = 1'b1;
                hs_bit     = ser_bit;
                byte_ready = ser_last;
            end
            ST_TRAIL: begin
                lp_line = LP_BRIDGE;
                lp_en   = 1'b0;
                hs_en   = 1'b1;
                hs_bit  = trail_q;
            end
            ST_EXIT:   lp_line = LP_STOP;
            default:   busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/hsb_tx_chk.sv
module hsb_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hs_req,
    input logic       byte_ready,
    input logic [1:0] lp_line,
    input logic       hs_en,
    input logic       lp_en,
    input logic       busy
);
    // R1 / R8: an idle lane sits at the stop level on the LP drivers
    a_r1_idle_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (lp_en && !hs_en && lp_line == 2'b11));

    // R8: a burst only starts from a request seen the cycle before, with LP-01
    a_r8_start_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(hs_req) && lp_line == 2'b01));

    // R2: the request level is left only towards the bridge level
    a_r2_req_to_bridge: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lp_en) && $past(lp_line) == 2'b01 && lp_line != 2'b01) |-> (lp_en && lp_line == 2'b00));

    // R3: LP drivers fall in the same cycle HS rises, straight from the bridge
    a_r3_handoff: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lp_en) |-> (hs_en && $rose(hs_en) && $past(lp_line) == 2'b00));

    // R7: HS driver falls in the same cycle LP returns, at the stop level
    a_r7_exit_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_en) |-> (lp_en && lp_line == 2'b11));

    // R5: byte handshake only while the HS driver is on
    a_r5_ready_in_hs: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready |-> (hs_en && !lp_en));
endmodule

bind hsb_tx_seq hsb_tx_chk u_hsb_tx_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hs_req     (hs_req),
    .byte_ready (byte_ready),
    .lp_line    (lp_line),
    .hs_en      (hs_en),
    .lp_en      (lp_en),
    .busy       (busy)
);

// File: tb/test_hsb_tx_seq.sv
`timescale 1ns/1ps
module test_hsb_tx_seq;
    localparam int CNT_W = 8;

    typedef struct packed {
        logic [1:0] lp;
        logic       hs;
        logic       lpe;
        logic       b;
        logic [3:0] req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hs_req = 1'b0;
    logic [CNT_W-1:0] t_lpx = 1, t_prep = 1, t_zero = 1, t_trail = 1, t_exit = 1;
    logic [7:0]       byte_data = 8'h00;
    logic             byte_valid = 1'b0;
    logic             byte_ready, hs_en, lp_en, hs_bit, busy;
    logic [1:0]       lp_line;

    exp_t       exp_q[$];
    logic [7:0] src_q[$];
    int         src_idx = 0;
    bit         src_on = 1'b0;
    int         n_run = 0, n_fail = 0, busy_cycles = 0;

    always #2.5 clk = ~clk;

    hsb_tx_seq #(.CNT_W(CNT_W)) i_hsb_tx_seq (
        .clk(clk), .rst_n(rst_n), .hs_req(hs_req),
        .t_lpx(t_lpx), .t_prep(t_prep), .t_zero(t_zero), .t_trail(t_trail), .t_exit(t_exit),
        .byte_data(byte_data), .byte_valid(byte_valid), .byte_ready(byte_ready),
        .lp_line(lp_line), .hs_en(hs_en), .lp_en(lp_en), .hs_bit(hs_bit), .busy(busy)
    );

    // byte source: drive on the falling edge, count a transfer when ready&valid
    initial forever begin
        @(negedge clk);
        byte_valid = src_on && (src_idx < src_q.size());
        byte_data  = (src_idx < src_q.size()) ? src_q[src_idx] : 8'h00;
        if (byte_ready && byte_valid) src_idx++;
    end

    // monitor: one expected item per busy cycle
    initial forever begin
        @(negedge clk);
        if (rst_n && busy) begin
            busy_cycles++;
            n_run++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R8: busy with nothing expected (actual busy=1, expected busy=0)");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (lp_line !== e.lp || hs_en !== e.hs || lp_en !== e.lpe || hs_bit !== e.b) begin
                    n_fail++;
                    $display("FAIL R%0d: actual lp=%b hs_en=%b lp_en=%b bit=%b, expected lp=%b hs_en=%b lp_en=%b bit=%b",
                             e.req, lp_line, hs_en, lp_en, hs_bit, e.lp, e.hs, e.lpe, e.b);
                end
            end
        end
    end

    task automatic push(input logic [1:0] lp, input logic hs, input logic lpe,
                        input logic b, input int req, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back('{lp, hs, lpe, b, 4'(req)});
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic check_idle(input string tag);
        check(lp_line == 2'b11 && lp_en && !hs_en && !hs_bit && !busy, tag,
              {lp_line, hs_en, lp_en, hs_bit, busy}, 6'b110100);
    endtask

    // driver: program intervals, load bytes, build the expected trace, start
    task automatic run_burst(input int lpx, input int prep, input int zero, input int trail,
                             input int ext, input logic [7:0] bytes[$], input int poke_at,
                             input string tag);
        logic last_bit;
        int   total;
        @(negedge clk);
        t_lpx = CNT_W'(lpx); t_prep = CNT_W'(prep); t_zero = CNT_W'(zero);
        t_trail = CNT_W'(trail); t_exit = CNT_W'(ext);
        src_q = bytes; src_idx = 0; src_on = 1'b1;
        push(2'b01, 0, 1, 0, 2, lpx);           // R2 request level
        push(2'b00, 0, 1, 0, 2, prep);          // R2 bridge level
        push(2'b00, 1, 0, 0, 3, zero);          // R3 zero preamble
        begin
            logic [7:0] sy;
            sy = 8'b00011101;                   // R4 first-sent bit on the left
            for (int i = 7; i >= 0; i--) push(2'b00, 1, 0, sy[i], 4, 1);
        end
        last_bit = 1'b1;
        foreach (bytes[k])
            for (int i = 0; i < 8; i++) begin   // R5 LSB first
                push(2'b00, 1, 0, bytes[k][i], 5, 1);
                last_bit = bytes[k][i];
            end
        push(2'b00, 1, 0, ~last_bit, 6, trail); // R6 trailer
        push(2'b11, 0, 1, 0, 7, ext);           // R7 closing stop
        total = exp_q.size();
        busy_cycles = 0;
        hs_req = 1'b1;
        @(negedge clk);
        hs_req = 1'b0;
        for (int c = 0; c < total + 20; c++) begin
            if (c == poke_at) hs_req = 1'b1;    // R8 request while busy
            if (c == poke_at + 2) hs_req = 1'b0;
            @(negedge clk);
            #0.1;
            if (!busy && exp_q.size() == 0) break;
        end
        hs_req = 1'b0;
        src_on = 1'b0;
        check(exp_q.size() == 0, {tag, " R8 trace consumed"}, exp_q.size(), 0);
        check(busy_cycles == total, {tag, " R8 busy length"}, busy_cycles, total);
        check(src_idx == bytes.size(), {tag, " R5 bytes taken"}, src_idx, bytes.size());
        check_idle({tag, " R1 idle after burst"});
        exp_q.delete();
    endtask

    initial begin
        logic [7:0] b2[$], b1[$], b0[$], b3[$];
        repeat (3) @(negedge clk);
        check_idle("R1 reset state");
        rst_n = 1'b1;
        // R1: byte_valid alone does not start a burst
        src_q = '{8'h55}; src_on = 1'b1;
        repeat (6) @(negedge clk);
        #0.1;
        check_idle("R1 valid without request");
        check(src_idx == 0, "R1 no byte taken while idle", src_idx, 0);
        src_on = 1'b0;

        b2 = '{8'hA5, 8'h3C};
        run_burst(2, 3, 4, 2, 3, b2, -1, "two bytes");
        b1 = '{8'h80};
        run_burst(1, 1, 1, 1, 1, b1, -1, "R9 unit intervals");
        b0 = '{};
        run_burst(2, 2, 2, 3, 2, b0, -1, "R6 empty payload");
        b3 = '{8'hFF, 8'h00, 8'h01};
        run_burst(3, 2, 5, 4, 2, b3, 12, "R8 request while busy");
        repeat (5) @(negedge clk);
        #0.1;
        check_idle("R8 ignored request left no burst");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule